// File: doc/BRIEF.md
# Synchronous Burst NOR Read Sequencer

This block turns a single read request from a host into a synchronous burst read on a 16-bit NOR flash. It generates the flash clock at half the system clock rate, pulses the address-valid strobe for one flash clock, and holds chip select and output enable. It then counts a programmable number of latency clocks and watches the flash wait line. That line's active level is selectable, and so is its timing: it can describe the current beat or the next one. The sequencer collects one or two 16-bit beats and hands a 32-bit word back to the host with a one-cycle done pulse.

The host raises a request with an address, a transfer size, a latency value and two wait-handling bits. All of these are captured on the acknowledge cycle. A 16-bit request becomes a one-beat burst and a 32-bit request becomes a two-beat burst. Chip select drops straight after the last beat is taken, the bus rests for one flash clock, and the result is reported. If the wait line stays active for too long, the access is cut short and reported with an error flag.

Top module: `nor_burst_rd`

## Requirements
- R1: While `rst` is high and after it is released, `mem_cs_n`, `mem_adv_n` and `mem_oe_n` are high, `mem_clk` is low, and `host_ack`, `done` and `err` are low.
- R2: A request seen while the sequencer is idle gets a one-cycle `host_ack`. On that cycle `host_addr`, `host_size`, `cfg_lat`, `cfg_wait_pol` and `cfg_wait_inline` are captured, and chip select and the address strobe go low. A request held high while an access is running is not acknowledged again and starts no second access.
- R3: From the acknowledge until the access ends, `mem_clk` toggles on every system clock (half rate). It is low whenever the sequencer is idle.
- R4: `mem_adv_n` is low for exactly one flash clock. That clock's rising edge is edge 0 of the access, and the host address is on `mem_addr` at that edge.
- R5: The latency count does not include edge 0. The wait line is first evaluated at rising edge `cfg_lat`+1, and no beat is taken earlier.
- R6: The wait line is active when it equals `cfg_wait_pol`: low when the bit is 0, high when it is 1.
- R7: With `cfg_wait_inline`=1, a beat is taken at the same rising edge where wait reads inactive. With `cfg_wait_inline`=0, the beat is taken at the next rising edge after an edge where wait read inactive.
- R8: During wait states the flash clock keeps running, chip select and output enable stay low, and no beat is taken. `mem_oe_n` is never low while `mem_cs_n` is high.
- R9: With `host_size`=0 one beat is read and returned in `rdata[15:0]`, with `rdata[31:16]` zero. With `host_size`=1 two beats are read: the first goes to `rdata[15:0]` and the second to `rdata[31:16]`.
- R10: Chip select and output enable go high on the falling flash-clock phase right after the last beat. The number of rising edges seen with chip select low is therefore the last beat's edge index plus one. After one idle flash clock, `done` pulses for one system clock with chip select high.
- R11: If 256 evaluated edges in a row take no beat, the access ends through the same release and `done` pulses with `err`=1 and `rdata`=0. `err` is never high without `done`.
- R12: With `cfg_lat`=0 and a flash that holds wait active through its real latency, the first beat is still the first one the wait line marks valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host read request |
| host_ack | output | 1 | One-cycle acknowledge; request fields captured |
| host_size | input | 1 | 0 = 16-bit read, 1 = 32-bit read |
| host_addr | input | AW | Flash word address |
| cfg_lat | input | LW | Latency clocks after the address cycle |
| cfg_wait_pol | input | 1 | Active level of the wait line |
| cfg_wait_inline | input | 1 | 1 = data valid on the edge wait goes inactive, 0 = one edge later |
| rdata | output | 2*DW | Read result, valid with `done` |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Wait timeout, valid with `done` |
| mem_clk | output | 1 | Flash clock, half the system clock |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | AW | Address to the flash |
| mem_dq | input | DW | Flash data |
| mem_wait | input | 1 | Flash wait line |

## Verification
The hardest case to reach is an off-by-one in where the first wait evaluation falls, because a flash that drives wait through its latency hides an early evaluation. The bench's flash model therefore holds wait inactive and drives junk data on every edge before the intended first evaluation. An early look takes junk, a late look runs into wait and then times out. The model also places beats at chosen edge indices and inserts wait states between them, and it counts the rising edges seen with chip select low, so the release point is checked exactly. Timeout is reached by a flash that never marks a beat valid.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LAT,
    ST_DATA,
    ST_REL
  } nbr_state_e;
endpackage

// File: rtl/nbr_phase.sv
// Flash clock generator: divides the system clock by two while an access runs.
module nbr_phase (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mclk,
  output logic rise,
  output logic fall
);
  logic ph;

  always_ff @(posedge clk) begin
    if (rst) ph <= 1'b0;
    else     ph <= run ? ~ph : 1'b0;
  end

  assign mclk = ph;
  // rise: this system edge drives the flash clock high (sample point)
  assign rise = run & ~ph;
  // fall: this system edge drives the flash clock low (launch point)
  assign fall = run & ph;
endmodule

// File: rtl/nbr_lat_cnt.sv
// Latency down-counter, loaded on accept, decremented on flash rising edges.
module nbr_lat_cnt #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] load_val,
  input  logic          dec,
  output logic          zero
);
  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (dec && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/nbr_wait_eval.sv
// Wait-line evaluation: polarity, same/next-edge mode and stall timeout.
module nbr_wait_eval #(
  parameter int TMO_LIMIT = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic sample,
  input  logic wait_in,
  input  logic pol,
  input  logic inline_mode,
  output logic take,
  output logic tmo
);
  localparam int TW = $clog2(TMO_LIMIT + 1);

  logic          ok;
  logic          prev_ok;
  logic [TW-1:0] stall_cnt;

  assign ok   = (wait_in != pol);
  assign take = sample & (inline_mode ? ok : prev_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ok   <= 1'b0;
      stall_cnt <= '0;
      tmo       <= 1'b0;
    end else if (clear) begin
      prev_ok   <= 1'b0;
      stall_cnt <= '0;
      tmo       <= 1'b0;
    end else if (sample) begin
      prev_ok <= ok;
      if (take) begin
        stall_cnt <= '0;
      end else if (stall_cnt == TW'(TMO_LIMIT)) begin
        tmo <= 1'b1;
      end else begin
        stall_cnt <= stall_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nbr_beat_store.sv
// Collects up to BEATS_MAX data beats, first beat in the lowest slot.
module nbr_beat_store #(
  parameter int DW        = 16,
  parameter int BEATS_MAX = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    two_beat,
  input  logic                    take,
  input  logic [DW-1:0]           dq,
  output logic [BEATS_MAX*DW-1:0] word,
  output logic                    last
);
  localparam int IW = $clog2(BEATS_MAX + 1);

  logic [IW-1:0] idx;
  logic [IW-1:0] need;
  logic [DW-1:0] slot [BEATS_MAX];

  assign need = two_beat ? IW'(2) : IW'(1);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx  <= '0;
      last <= 1'b0;
    end else if (take && !last) begin
      idx <= idx + IW'(1);
      if (idx + IW'(1) == need) last <= 1'b1;
    end
  end

  for (genvar g = 0; g < BEATS_MAX; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clear)                          slot[g] <= '0;
      else if (take && !last && idx == IW'(g))   slot[g] <= dq;
    end
    assign word[g*DW +: DW] = slot[g];
  end
endmodule

// File: rtl/nor_burst_rd.sv
module nor_burst_rd
  import nbr_pkg::*;
#(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int LW        = 4,
  parameter int TMO_LIMIT = 255
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_req,
  output logic            host_ack,
  input  logic            host_size,
  input  logic [AW-1:0]   host_addr,
  input  logic [LW-1:0]   cfg_lat,
  input  logic            cfg_wait_pol,
  input  logic            cfg_wait_inline,
  output logic [2*DW-1:0] rdata,
  output logic            done,
  output logic            err,
  output logic            mem_clk,
  output logic            mem_adv_n,
  output logic            mem_cs_n,
  output logic            mem_oe_n,
  output logic [AW-1:0]   mem_addr,
  input  logic [DW-1:0]   mem_dq,
  input  logic            mem_wait
);
  localparam int BEATS_MAX = 2;
  localparam int RW        = BEATS_MAX * DW;

  nbr_state_e     state;
  logic           ack_q, done_q, err_q;
  logic [RW-1:0]  rdata_q;
  logic           cs_n_q, adv_n_q, oe_n_q;
  logic [AW-1:0]  addr_q;
  logic           size_q, pol_q, inl_q;

  logic           run, rise, fall;
  logic           accept;
  logic           lat_zero;
  logic           take, tmo_hit;
  logic [RW-1:0]  beat_word;
  logic           burst_last;

  assign run    = (state != ST_IDLE);
  assign accept = (state == ST_IDLE) && host_req;

  nbr_phase u_phase (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .mclk (mem_clk),
    .rise (rise),
    .fall (fall)
  );

  nbr_lat_cnt #(.LW(LW)) u_lat (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (cfg_lat),
    .dec      (rise && state == ST_LAT),
    .zero     (lat_zero)
  );

  nbr_wait_eval #(.TMO_LIMIT(TMO_LIMIT)) u_wait (
    .clk         (clk),
    .rst         (rst),
    .clear       (accept),
    .sample      (rise && state == ST_DATA),
    .wait_in     (mem_wait),
    .pol         (pol_q),
    .inline_mode (inl_q),
    .take        (take),
    .tmo         (tmo_hit)
  );

  nbr_beat_store #(.DW(DW), .BEATS_MAX(BEATS_MAX)) u_beats (
    .clk      (clk),
    .rst      (rst),
    .clear    (accept),
    .two_beat (size_q),
    .take     (take),
    .dq       (mem_dq),
    .word     (beat_word),
    .last     (burst_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
      cs_n_q  <= 1'b1;
      adv_n_q <= 1'b1;
      oe_n_q  <= 1'b1;
      addr_q  <= '0;
      size_q  <= 1'b0;
      pol_q   <= 1'b0;
      inl_q   <= 1'b0;
    end else begin
      ack_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (host_req) begin
            ack_q   <= 1'b1;
            cs_n_q  <= 1'b0;
            adv_n_q <= 1'b0;
            addr_q  <= host_addr;
            size_q  <= host_size;
            pol_q   <= cfg_wait_pol;
            inl_q   <= cfg_wait_inline;
            state   <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (fall) begin
            adv_n_q <= 1'b1;
            oe_n_q  <= 1'b0;
            state   <= lat_zero ? ST_DATA : ST_LAT;
          end
        end
        ST_LAT: begin
          if (fall && lat_zero) state <= ST_DATA;
        end
        ST_DATA: begin
          if (fall && (burst_last || tmo_hit)) begin
            cs_n_q <= 1'b1;
            oe_n_q <= 1'b1;
            state  <= ST_REL;
          end
        end
        ST_REL: begin
          if (fall) begin
            done_q  <= 1'b1;
            err_q   <= tmo_hit;
            rdata_q <= tmo_hit ? '0 : beat_word;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign host_ack  = ack_q;
  assign done      = done_q;
  assign err       = err_q;
  assign rdata     = rdata_q;
  assign mem_cs_n  = cs_n_q;
  assign mem_adv_n = adv_n_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_addr  = addr_q;
endmodule

// File: rtl/nbr_chk.sv
module nbr_chk (
  input logic clk,
  input logic rst,
  input logic host_ack,
  input logic done,
  input logic err,
  input logic mem_clk,
  input logic mem_cs_n,
  input logic mem_adv_n,
  input logic mem_oe_n
);
  // R2
  ack_starts_access_chk: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> (!mem_cs_n && !mem_adv_n));

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);

  // R4
  adv_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_adv_n && $past(mem_adv_n)) |=> !mem_adv_n);

  // R4
  adv_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_adv_n && !$past(mem_adv_n)) |=> mem_adv_n);

  // R3
  clk_runs_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !$past(mem_cs_n)) |-> (mem_clk != $past(mem_clk)));

  // R8
  oe_under_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_cs_n);

  // R10
  done_released_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (mem_cs_n && mem_oe_n && mem_adv_n));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);
endmodule

bind nor_burst_rd nbr_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_ack  (host_ack),
  .done      (done),
  .err       (err),
  .mem_clk   (mem_clk),
  .mem_cs_n  (mem_cs_n),
  .mem_adv_n (mem_adv_n),
  .mem_oe_n  (mem_oe_n)
);

// File: tb/nor_burst_rd_bench.sv
`timescale 1ns/1ps
module nor_burst_rd_bench;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_req = 1'b0;
  logic          host_ack;
  logic          host_size = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [3:0]    cfg_lat = '0;
  logic          cfg_wait_pol = 1'b0;
  logic          cfg_wait_inline = 1'b0;
  logic [31:0]   rdata;
  logic          done, err;
  logic          mem_clk, mem_adv_n, mem_cs_n, mem_oe_n;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_dq = 16'h0;
  logic          mem_wait = 1'b1;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  nor_burst_rd u_nor_burst_rd (
    .clk(clk), .rst(rst), .host_req(host_req), .host_ack(host_ack),
    .host_size(host_size), .host_addr(host_addr), .cfg_lat(cfg_lat),
    .cfg_wait_pol(cfg_wait_pol), .cfg_wait_inline(cfg_wait_inline),
    .rdata(rdata), .done(done), .err(err), .mem_clk(mem_clk),
    .mem_adv_n(mem_adv_n), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_wait(mem_wait)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Flash model: beats at edge indices md0/md1, wait inactive before mws.
  int          md0, md1, mws;
  logic        mpol, minl;
  logic [15:0] mb0, mb1;
  int          kk = 0;
  int          cs_edges = 0;
  logic [AW-1:0] addr_seen = '0;

  function automatic bit is_beat(input int e);
    return (e == md0) || (e == md1);
  endfunction

  always @(posedge mem_clk) begin
    if (!mem_adv_n) begin
      kk = 0;
      cs_edges = 1;
      addr_seen = mem_addr;
    end else begin
      kk = kk + 1;
      if (!mem_cs_n) cs_edges = cs_edges + 1;
    end
  end

  always @(negedge mem_clk) begin
    int e;
    bit idle_ok;
    e = kk + 1;
    idle_ok = (e < mws) || (minl ? is_beat(e) : is_beat(e + 1));
    mem_wait = idle_ok ? ~mpol : mpol;
    if (e == md0)      mem_dq = mb0;
    else if (e == md1) mem_dq = mb1;
    else               mem_dq = 16'hDEAD ^ e[15:0];
  end

  typedef struct {
    logic [31:0]   rd;
    logic          er;
    logic [AW-1:0] ad;
    int            edges;
    string         tag;
  } exp_t;
  exp_t sb[$];

  // Driver: program the flash model, push the expected result, run the request.
  task automatic run_txn(input logic sz, input logic [AW-1:0] a, input logic [3:0] lt,
                         input logic pol, input logic inl, input int ws, input int d0,
                         input int d1, input logic [15:0] b0, input logic [15:0] b1,
                         input logic e_err, input int e_edges, input string tag);
    exp_t x;
    md0 = d0; md1 = d1; mws = ws; mpol = pol; minl = inl; mb0 = b0; mb1 = b1;
    x.er = e_err;
    x.rd = e_err ? 32'h0 : (sz ? {b1, b0} : {16'h0, b0});
    x.ad = a;
    x.edges = e_edges;
    x.tag = tag;
    sb.push_back(x);
    @(negedge clk);
    host_req = 1'b1; host_size = sz; host_addr = a; cfg_lat = lt;
    cfg_wait_pol = pol; cfg_wait_inline = inl;
    forever begin
      @(negedge clk);
      if (host_ack) break;
    end
    @(negedge clk);
    // R2: request still held, sequencer busy, no second acknowledge
    chk(host_ack == 1'b0, "R2 ack while busy", {31'h0, host_ack}, 32'h0);
    host_req = 1'b0;
    forever begin
      @(negedge clk);
      if (done) break;
    end
    @(negedge clk);
  endtask

  // Monitor: compare each completion against the oldest expected item.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2 unexpected completion", 32'h1, 32'h0);
      end else begin
        exp_t x;
        x = sb.pop_front();
        chk(rdata == x.rd, {x.tag, " R9 rdata"}, rdata, x.rd);
        chk(err == x.er, {x.tag, " R11 err"}, {31'h0, err}, {31'h0, x.er});
        chk(addr_seen == x.ad, {x.tag, " R4 address"}, 32'(addr_seen), 32'(x.ad));
        chk(cs_edges == x.edges, {x.tag, " R10 cs edges"}, 32'(cs_edges), 32'(x.edges));
        chk(mem_cs_n && mem_oe_n, {x.tag, " R10 released"}, {30'h0, mem_cs_n, mem_oe_n}, 32'h3);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    md0 = -1; md1 = -1; mws = 0; mpol = 1'b0; minl = 1'b0; mb0 = '0; mb1 = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_cs_n && mem_adv_n && mem_oe_n && !mem_clk, "R1 bus idle in reset",
        {28'h0, mem_cs_n, mem_adv_n, mem_oe_n, mem_clk}, 32'he);
    chk(!host_ack && !done && !err, "R1 host outputs in reset",
        {29'h0, host_ack, done, err}, 32'h0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(mem_cs_n && !mem_clk, "R1 R3 idle after reset", {30'h0, mem_cs_n, mem_clk}, 32'h2);

    // R5 R9: 16-bit, exact latency, wait quiet before edge 3; second beat ignored
    run_txn(1'b0, 24'h00_1230, 4'd2, 1'b0, 1'b1, 3, 3, 4, 16'h1234, 16'hBEEF, 1'b0, 4, "T1 R5");
    // R6: active-high wait, 32-bit back-to-back beats
    run_txn(1'b1, 24'h00_4560, 4'd3, 1'b1, 1'b1, 4, 4, 5, 16'hA1B2, 16'hC3D4, 1'b0, 6, "T2 R6");
    // R7: next-edge mode, junk on edge 2 catches an early evaluation
    run_txn(1'b1, 24'h12_0002, 4'd1, 1'b0, 1'b0, 2, 3, 4, 16'h5566, 16'h7788, 1'b0, 5, "T3 R7");
    // R8: wait states before and between beats
    run_txn(1'b1, 24'hAB_CDE0, 4'd2, 1'b0, 1'b1, 3, 5, 9, 16'h0F0F, 16'hF0F0, 1'b0, 10, "T4 R8");
    // R7 R6: next-edge mode, active-high wait, gap between beats
    run_txn(1'b1, 24'h00_0777, 4'd0, 1'b1, 1'b0, 1, 6, 8, 16'h1357, 16'h2468, 1'b0, 9, "T5 R7");
    // R12: minimum latency, flash holds wait through its latency of 7
    run_txn(1'b1, 24'h3F_0000, 4'd0, 1'b0, 1'b1, 1, 7, 8, 16'h9ABC, 16'hDEF0, 1'b0, 9, "T6 R12");
    // R11: wait never released, 256 empty edges from edge 2
    run_txn(1'b0, 24'h00_0BAD, 4'd1, 1'b0, 1'b1, 2, 100000, 100001, 16'h1111, 16'h2222, 1'b1, 258, "T7 R11");
    // R2 R7: normal access after a timeout
    run_txn(1'b0, 24'h00_0042, 4'd4, 1'b0, 1'b0, 5, 6, 100, 16'h4242, 16'h0000, 1'b0, 7, "T8 R2");

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R2 all completions seen", 32'(sb.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule